// File: doc/BRIEF.md
# Return Address Stack with Overflow Policy

This block is the hidden return-address store of a small processor core. When a subroutine call begins or an interrupt is acknowledged, the core hands the current program counter to the block, which keeps it. On a return, the block gives back the most recently saved value. The storage and its pointer cannot be read or written by software. The only ways to change them are the push and pop strobes.

The block holds sixteen addresses. A call and an interrupt behave differently when all sixteen slots are in use. A call still pushes: the new address overwrites the oldest one, so the sixteen most recent addresses survive. An interrupt acknowledge is refused instead. The block raises an inhibit output, and the interrupt controller keeps its request pending until a return frees a slot. The interrupt flag itself and the program counter register live outside this block.

Top module: `ret_addr_stack`

## Requirements
- R1: The stack holds exactly DEPTH (default 16) entries. `full` is low after DEPTH-1 pushes from empty and high after DEPTH pushes.
- R2: After reset the stack is empty, and `full` and `irq_inhibit` are both low.
- R3: A call saves `pc_in`. While `pop` is high, `pop_pc` shows the most recently saved address that has not yet been popped, so values come back in last-in first-out order.
- R4: A pop from a non-empty stack removes one entry. A single pop from a full stack clears `full` on the following cycle.
- R5: A call made while the stack is full still stores `pc_in` and leaves the stack full. The oldest entry is lost, so DEPTH pops return the latest DEPTH addresses, newest first.
- R6: `irq_inhibit` is high in exactly the cycles in which the stack is full.
- R7: An interrupt acknowledge while the stack is full pushes nothing. The next pop returns the same top entry that was there before the acknowledge.
- R8: An interrupt acknowledge while the stack is not full saves `pc_in` exactly as a call does.
- R9: A pop from an empty stack leaves the stack empty. `pop_pc` then shows the slot just below the write position, and DEPTH further pushes are needed to make the stack full.
- R10: When several strobes are high in the same cycle, pop wins over call, and call wins over interrupt acknowledge. Only the winning operation changes the stack.
- R11: `full` is derived from the registered occupancy without any extra register stage. It rises in the cycle right after the clock edge that stores the DEPTH-th entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| call_push | input | 1 | Save `pc_in` at the start of a subroutine call |
| irq_push | input | 1 | Interrupt acknowledge; saves `pc_in` unless the stack is full |
| pop | input | 1 | Return; removes the top entry |
| pc_in | input | PC_W | Address to save |
| pop_pc | output | PC_W | Current top entry, the return address when `pop` is high |
| full | output | 1 | All DEPTH slots occupied |
| irq_inhibit | output | 1 | Interrupt acknowledge must be held off |

## Verification
The bench runs several kinds of input sequence. Plain call/return nesting shows whether last-in first-out order is kept. A run of twenty calls separates overwriting the oldest entry from refusing or corrupting the newest. Acknowledges issued on a full stack, and again after one return, show whether the call and interrupt policies are kept apart. Popping past empty and issuing strobes together in one cycle expose the empty-stack and priority corners. A reference model compares every output on every cycle throughout.

// File: rtl/ras_pkg.sv
package ras_pkg;
    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_PUSH = 2'd1,
        OP_POP  = 2'd2
    } ras_op_e;
endpackage

// File: rtl/ras_store.sv
module ras_store #(
    parameter int DEPTH = 16,
    parameter int PC_W  = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [IDX_W-1:0] waddr_i,
    input  logic [PC_W-1:0]  wdata_i,
    input  logic [IDX_W-1:0] raddr_i,
    output logic [PC_W-1:0]  rdata_o
);
    logic [PC_W-1:0] mem_q [DEPTH];
    logic [PC_W-1:0] mem_d [DEPTH];
    logic [DEPTH-1:0] sel;

    // one write-select line per slot
    for (genvar g = 0; g < DEPTH; g++) begin : g_sel
        assign sel[g] = we_i && (waddr_i == IDX_W'(g));
    end

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = sel[i] ? wdata_i : mem_q[i];
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n) mem_q[i] <= '0;
            else        mem_q[i] <= mem_d[i];
        end
    end

    assign rdata_o = mem_q[raddr_i];

    // R3: a written slot holds the written value on the next cycle
    p_slot_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> mem_q[$past(waddr_i)] == $past(wdata_i));
endmodule

// File: rtl/ras_ctrl.sv
module ras_ctrl
    import ras_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             call_i,
    input  logic             irq_i,
    input  logic             pop_i,
    output ras_op_e          op_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             full_o,
    output logic             inhibit_o
);
    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic [CNT_W-1:0] cnt;
    } ctrl_t;

    ctrl_t st_q, st_d;
    ras_op_e op;

    assign full_o    = (st_q.cnt == CNT_W'(DEPTH));
    assign inhibit_o = full_o;

    always_comb begin
        st_d = st_q;
        if (pop_i)                  op = OP_POP;
        else if (call_i)            op = OP_PUSH;
        else if (irq_i && !full_o)  op = OP_PUSH;
        else                        op = OP_IDLE;

        case (op)
            OP_PUSH: begin
                st_d.idx = st_q.idx + 1'b1;
                if (!full_o) st_d.cnt = st_q.cnt + 1'b1;
            end
            OP_POP: begin
                if (st_q.cnt != '0) begin
                    st_d.idx = st_q.idx - 1'b1;
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign op_o  = op;
    assign idx_o = st_q.idx;

    p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(DEPTH));
    p_pop_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && st_q.cnt != '0) |=> st_q.cnt == $past(st_q.cnt) - 1'b1);
    p_call_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (call_i && !pop_i && full_o) |=> full_o && st_q.idx == $past(st_q.idx) + 1'b1);
    p_irq_blocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_i && !call_i && !pop_i && full_o) |=> $stable(st_q.idx) && full_o);
    p_pop_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && st_q.cnt == '0) |=> st_q.cnt == '0 && $stable(st_q.idx));
    p_pop_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && (call_i || irq_i) && st_q.cnt != '0) |=> !full_o);
endmodule

// File: rtl/ret_addr_stack.sv
module ret_addr_stack
    import ras_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int PC_W  = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            call_push,
    input  logic            irq_push,
    input  logic            pop,
    input  logic [PC_W-1:0] pc_in,
    output logic [PC_W-1:0] pop_pc,
    output logic            full,
    output logic            irq_inhibit
);
    ras_op_e          op;
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] top_idx;

    ras_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .call_i    (call_push),
        .irq_i     (irq_push),
        .pop_i     (pop),
        .op_o      (op),
        .idx_o     (idx),
        .full_o    (full),
        .inhibit_o (irq_inhibit)
    );

    assign top_idx = idx - 1'b1;

    ras_store #(.DEPTH(DEPTH), .PC_W(PC_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (op == OP_PUSH),
        .waddr_i (idx),
        .wdata_i (pc_in),
        .raddr_i (top_idx),
        .rdata_o (pop_pc)
    );

    // R6: the inhibit never drops while the stack stays full
    p_inhibit_tracks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop) |=> irq_inhibit);
endmodule

// File: tb/ret_addr_stack_bench.sv
module ret_addr_stack_bench;
    localparam int DEPTH = 16;
    localparam int PC_W  = 16;

    logic clk = 0;
    logic rst_n = 0;
    logic call_push = 0, irq_push = 0, pop = 0;
    logic [PC_W-1:0] pc_in = '0;
    logic [PC_W-1:0] pop_pc;
    logic full, irq_inhibit;

    int total = 0, bad = 0;
    int m_mem[DEPTH];
    int m_pos = 0;
    int m_cnt = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    ret_addr_stack #(.DEPTH(DEPTH), .PC_W(PC_W)) u_ret_addr_stack (
        .clk(clk), .rst_n(rst_n), .call_push(call_push), .irq_push(irq_push),
        .pop(pop), .pc_in(pc_in), .pop_pc(pop_pc), .full(full),
        .irq_inhibit(irq_inhibit)
    );

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // compare outputs with the model, then drive one cycle of strobes
    task automatic step(bit c, bit i, bit p, int pc, string tag);
        chk({tag, " pop_pc R3"}, pop_pc, m_mem[(m_pos + DEPTH - 1) % DEPTH]);
        chk({tag, " full R11"}, full, m_cnt == DEPTH);
        chk({tag, " inhibit R6"}, irq_inhibit, m_cnt == DEPTH);
        call_push = c; irq_push = i; pop = p; pc_in = PC_W'(pc);
        if (p) begin
            if (m_cnt > 0) begin
                m_pos = (m_pos + DEPTH - 1) % DEPTH;
                m_cnt--;
            end
        end else if (c || (i && m_cnt < DEPTH)) begin
            m_mem[m_pos] = pc;
            m_pos = (m_pos + 1) % DEPTH;
            if (m_cnt < DEPTH) m_cnt++;
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog R2 actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < DEPTH; k++) m_mem[k] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        chk("reset full R2", full, 0);
        chk("reset inhibit R2", irq_inhibit, 0);

        // R3 nesting
        step(1, 0, 0, 11, "R3");
        step(1, 0, 0, 22, "R3");
        step(0, 0, 1, 0, "R3");
        chk("R3 top after pop", pop_pc, 11);
        step(0, 0, 1, 0, "R3");

        // R9 pop on empty
        step(0, 0, 1, 0, "R9");
        step(0, 0, 1, 0, "R9");

        // R1 fill to depth, R8 irq push when not full
        for (int k = 0; k < DEPTH - 1; k++) step(1, 0, 0, 100 + k, "R1");
        chk("R1 not full at DEPTH-1", full, 0);
        step(0, 1, 0, 500, "R8");
        chk("R1 full at DEPTH", full, 1);
        chk("R8 irq pushed pc", pop_pc, 500);

        // R7 irq while full ignored
        step(0, 1, 0, 777, "R7");
        chk("R7 top unchanged", pop_pc, 500);
        chk("R6 inhibit while full", irq_inhibit, 1);

        // R4 one pop clears full, then irq allowed
        step(0, 0, 1, 0, "R4");
        chk("R4 full cleared", full, 0);
        step(0, 1, 0, 600, "R4");
        chk("R4 irq accepted after room", pop_pc, 600);

        // R5 overflow on calls
        for (int k = 0; k < 20; k++) step(1, 0, 0, 1000 + k, "R5");
        chk("R5 still full", full, 1);
        for (int k = 0; k < DEPTH; k++) begin
            chk("R5 order", pop_pc, 1019 - k);
            step(0, 0, 1, 0, "R5");
        end
        chk("R5 empty after DEPTH pops", full, 0);

        // R9 then DEPTH pushes needed
        step(0, 0, 1, 0, "R9");
        for (int k = 0; k < DEPTH - 1; k++) step(1, 0, 0, 2000 + k, "R9");
        chk("R9 not full after DEPTH-1", full, 0);
        step(1, 0, 0, 2015, "R9");
        chk("R9 full after DEPTH", full, 1);

        // R10 priority
        step(1, 1, 1, 3000, "R10");
        chk("R10 pop wins", pop_pc, 2014);
        chk("R10 pop wins full", full, 0);
        step(1, 1, 0, 3100, "R10");
        chk("R10 call wins", pop_pc, 3100);
        step(0, 0, 0, 0, "R10");
        step(0, 0, 1, 0, "R10");
        chk("R10 only one pushed", pop_pc, 2014);
        for (int k = 0; k < 8; k++) step(k[0], k[1], k[2], 4000 + k, "mix");
        step(0, 0, 0, 0, "end");

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule